// File: doc/BRIEF.md
# Block Copy and Search Sequencer

This block executes the eight byte-wide block instructions of an 8-bit processor with 16-bit register pairs. Four of them copy and four of them search. It holds a source/search pointer, a destination pointer, a byte counter, an accumulator and a flag byte. It walks memory through one synchronous byte port that has a valid/ready handshake. A copy and a search use the same pointer, counter and flag logic. The only differences are whether a write follows the read, and which flags the step produces.

The surrounding core first writes the registers through a load strobe while the block is idle. It then pulses `start` together with the byte that follows the escape prefix. The block raises `busy` until it pulses `done`. The single-step forms perform one step. The repeating forms continue until the counter runs out, or, for a search, until the first byte that equals the accumulator. An opcode outside the eight returns `done` together with `illegal` and changes nothing.

Top module: `blkx_engine`

## Requirements
- R1: During and after reset, pointers, counter, accumulator and flags read zero, and `busy`, `done`, `illegal` and `mem_valid` are low.
- R2: The opcode pattern 101x_x00x is legal. In a legal opcode, bit 0 selects search (1) or copy (0), bit 3 selects decrement (1) or increment (0), and bit 4 selects repeat (1) or single step (0).
- R3: A copy step reads the byte at `hl` with `mem_we` low. It then writes that byte to address `de` with `mem_we` high. The read always comes first.
- R4: Each step decrements `bc` by one. A copy moves both `hl` and `de` by one in the selected direction, and both wrap at the address width.
- R5: The flag byte has sign at bit 7, zero at bit 6, half-carry at bit 4, parity/overflow at bit 2, subtract at bit 1 and carry at bit 0. A copy step clears half-carry and subtract and sets parity/overflow exactly when the new `bc` is nonzero. It leaves bits 7, 6, 5, 3 and 0 unchanged.
- R6: A repeating copy steps until `bc` reaches zero and raises `done` only then. Overlapping ranges are handled byte by byte in the order of the steps.
- R7: A search step reads the byte at `hl` and sets the flags as follows:
  - zero is set when the byte equals `acc`;
  - sign is bit 7 of `acc` minus the byte;
  - half-carry is set when the low nibble of `acc` is below the low nibble of the byte;
  - subtract is set;
  - parity/overflow is set when the new `bc` is nonzero;
  - bits 5, 3 and 0 are kept.
  It moves only `hl`. It never writes memory and never changes `acc`.
- R8: A repeating search stops after the first step that finds a match, even if `bc` is still nonzero. Otherwise it stops when `bc` reaches zero.
- R9: A start with `bc` equal to zero runs 2^AW steps.
- R10: While `mem_valid` is high and `mem_ready` is low, the address, write enable and write data hold steady.
- R11: An illegal opcode pulses `done` and `illegal` together in the cycle after `start`, and leaves all registers unchanged.
- R12: `ld_en` loads the five registers only while the block is idle and `start` is low. While the block is busy, `ld_en` has no effect.
- R13: `busy` is high from the cycle after a legal start until `done`, and `done` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load strobe for the registers |
| ld_hl | input | AW | Load value, source/search pointer |
| ld_de | input | AW | Load value, destination pointer |
| ld_bc | input | AW | Load value, byte counter |
| ld_acc | input | 8 | Load value, accumulator |
| ld_flags | input | 8 | Load value, flag byte |
| start | input | 1 | Begin an instruction |
| opcode | input | 8 | Byte after the escape prefix |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Opcode rejected, pulses with done |
| hl | output | AW | Source/search pointer |
| de | output | AW | Destination pointer |
| bc | output | AW | Byte counter |
| acc | output | 8 | Accumulator |
| flags | output | 8 | Flag byte |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Write enable |
| mem_valid | output | 1 | Access request |
| mem_ready | input | 1 | Access accepted this cycle |
| mem_rdata | input | 8 | Read data, valid with mem_ready |

## Verification
The bench builds the block with AW set to 8. At that width the whole memory is a 256-byte model, so every byte can be compared after each instruction. The same width makes a zero count a 256-step run, so the 2^AW wraparound of R9 fits easily in a short run. The bench runs alternate instructions with a stalling `mem_ready` pattern. This exercises the request-hold behaviour on reads and on writes.

// File: rtl/blkx_pkg.sv
package blkx_pkg;

  localparam int FL_S = 7;
  localparam int FL_Z = 6;
  localparam int FL_H = 4;
  localparam int FL_P = 2;
  localparam int FL_N = 1;
  localparam int FL_C = 0;

  typedef struct packed {
    logic legal;
    logic cmp;
    logic down;
    logic rep;
  } blkx_op_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } blkx_state_t;

  // copy step: H and N cleared, P from counter, rest kept
  function automatic logic [7:0] copy_flags(input logic [7:0] f_old, input logic cnt_nz);
    logic [7:0] f;
    f = f_old;
    f[FL_H] = 1'b0;
    f[FL_N] = 1'b0;
    f[FL_P] = cnt_nz;
    return f;
  endfunction

  // search step: discarded subtraction acc - byte
  function automatic logic [7:0] search_flags(input logic [7:0] f_old, input logic [7:0] a,
                                              input logic [7:0] m, input logic cnt_nz);
    logic [7:0] diff;
    logic [7:0] f;
    diff = a - m;
    f = f_old;
    f[FL_S] = diff[7];
    f[FL_Z] = (diff == 8'h00);
    f[FL_H] = (a[3:0] < m[3:0]);
    f[FL_P] = cnt_nz;
    f[FL_N] = 1'b1;
    return f;
  endfunction

endpackage

// File: rtl/blkx_decode.sv
module blkx_decode
  import blkx_pkg::*;
(
  input  logic [7:0] opcode_i,
  output blkx_op_t   op_o
);
  always_comb begin
    op_o.legal = (opcode_i[7:5] == 3'b101) && (opcode_i[2:1] == 2'b00);
    op_o.cmp   = opcode_i[0];
    op_o.down  = opcode_i[3];
    op_o.rep   = opcode_i[4];
  end
endmodule

// File: rtl/blkx_ptrstep.sv
module blkx_ptrstep #(
  parameter int W = 16
) (
  input  logic [W-1:0] ptr_i,
  input  logic         down_i,
  output logic [W-1:0] ptr_o
);
  localparam logic [W-1:0] ONE = W'(1);
  assign ptr_o = down_i ? (ptr_i - ONE) : (ptr_i + ONE);
endmodule

// File: rtl/blkx_flagcalc.sv
module blkx_flagcalc
  import blkx_pkg::*;
(
  input  logic       cmp_i,
  input  logic [7:0] flags_i,
  input  logic [7:0] acc_i,
  input  logic [7:0] byte_i,
  input  logic       cnt_nz_i,
  output logic [7:0] flags_o,
  output logic       match_o
);
  assign flags_o = cmp_i ? search_flags(flags_i, acc_i, byte_i, cnt_nz_i)
                         : copy_flags(flags_i, cnt_nz_i);
  assign match_o = (acc_i == byte_i);
endmodule

// File: rtl/blkx_engine.sv
module blkx_engine
  import blkx_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_hl,
  input  logic [AW-1:0] ld_de,
  input  logic [AW-1:0] ld_bc,
  input  logic [7:0]    ld_acc,
  input  logic [7:0]    ld_flags,
  input  logic          start,
  input  logic [7:0]    opcode,
  output logic          busy,
  output logic          done,
  output logic          illegal,
  output logic [AW-1:0] hl,
  output logic [AW-1:0] de,
  output logic [AW-1:0] bc,
  output logic [7:0]    acc,
  output logic [7:0]    flags,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          mem_we,
  output logic          mem_valid,
  input  logic          mem_ready,
  input  logic [7:0]    mem_rdata
);
  localparam logic [AW-1:0] ONE = AW'(1);

  blkx_state_t   state_q;
  blkx_op_t      op_q, dec_op;
  logic [AW-1:0] hl_q, de_q, bc_q;
  logic [AW-1:0] hl_nx, de_nx, bc_nx;
  logic [7:0]    acc_q, flags_q, byte_q, flags_nx;
  logic          done_q, ill_q, match;

  // named events for checking
  logic step_evt, last_step, ld_take;

  blkx_decode u_dec (.opcode_i(opcode), .op_o(dec_op));

  blkx_ptrstep #(.W(AW)) u_hl_step (.ptr_i(hl_q), .down_i(op_q.down), .ptr_o(hl_nx));
  blkx_ptrstep #(.W(AW)) u_de_step (.ptr_i(de_q), .down_i(op_q.down), .ptr_o(de_nx));
  blkx_ptrstep #(.W(AW)) u_bc_step (.ptr_i(bc_q), .down_i(1'b1),      .ptr_o(bc_nx));

  blkx_flagcalc u_flags (
    .cmp_i   (op_q.cmp),
    .flags_i (flags_q),
    .acc_i   (acc_q),
    .byte_i  (mem_rdata),
    .cnt_nz_i(bc_nx != '0),
    .flags_o (flags_nx),
    .match_o (match)
  );

  assign step_evt  = mem_ready && (((state_q == ST_READ) && op_q.cmp) || (state_q == ST_WRITE));
  assign last_step = !op_q.rep || (bc_nx == '0) || (op_q.cmp && match);
  assign ld_take   = (state_q == ST_IDLE) && !start && ld_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      hl_q    <= '0;
      de_q    <= '0;
      bc_q    <= '0;
      acc_q   <= '0;
      flags_q <= '0;
      byte_q  <= '0;
      done_q  <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (dec_op.legal) begin
              op_q    <= dec_op;
              state_q <= ST_READ;
            end else begin
              done_q <= 1'b1;
              ill_q  <= 1'b1;
            end
          end else if (ld_take) begin
            hl_q    <= ld_hl;
            de_q    <= ld_de;
            bc_q    <= ld_bc;
            acc_q   <= ld_acc;
            flags_q <= ld_flags;
          end
        end
        ST_READ: begin
          if (mem_ready && !op_q.cmp) begin
            byte_q  <= mem_rdata;
            state_q <= ST_WRITE;
          end
        end
        default: ;
      endcase
      if (step_evt) begin
        hl_q    <= hl_nx;
        bc_q    <= bc_nx;
        flags_q <= flags_nx;
        if (!op_q.cmp) de_q <= de_nx;
        if (last_step) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end else begin
          state_q <= ST_READ;
        end
      end
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign illegal   = ill_q;
  assign hl        = hl_q;
  assign de        = de_q;
  assign bc        = bc_q;
  assign acc       = acc_q;
  assign flags     = flags_q;
  assign mem_valid = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_addr  = (state_q == ST_WRITE) ? de_q : hl_q;
  assign mem_wdata = byte_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R13
  AST_ILL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done && !busy); // R11
  AST_COPY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    done && !illegal && !op_q.cmp |-> !flags[FL_H] && !flags[FL_N]); // R5
  AST_SEARCH_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    done && !illegal && op_q.cmp |-> flags[FL_N]); // R7
  AST_SEARCH_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> !op_q.cmp); // R7
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> bc == $past(bc) - ONE); // R4
  AST_REP_COPY_END: assert property (@(posedge clk) disable iff (!rst_n)
    done && !illegal && op_q.rep && !op_q.cmp |-> bc == '0); // R6
  AST_ACC_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(acc)); // R12

endmodule

// File: tb/blkx_engine_bench.sv
module blkx_engine_bench;
  localparam int AW = 8;
  localparam int NV = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_hl = '0, ld_de = '0, ld_bc = '0;
  logic [7:0]    ld_acc = '0, ld_flags = '0;
  logic          start = 1'b0;
  logic [7:0]    opcode = '0;
  logic          busy, done, illegal;
  logic [AW-1:0] hl, de, bc, mem_addr;
  logic [7:0]    acc, flags, mem_wdata, mem_rdata;
  logic          mem_we, mem_valid;
  logic          mem_ready = 1'b1;
  logic          stall = 1'b0;
  int            rdy_cnt = 0;

  logic [7:0] mem     [256];
  logic [7:0] ref_mem [256];

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  blkx_engine #(.AW(AW)) u_blkx_engine (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_hl(ld_hl), .ld_de(ld_de), .ld_bc(ld_bc),
    .ld_acc(ld_acc), .ld_flags(ld_flags), .start(start), .opcode(opcode),
    .busy(busy), .done(done), .illegal(illegal), .hl(hl), .de(de), .bc(bc),
    .acc(acc), .flags(flags), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk)
    if (mem_valid && mem_we && mem_ready) mem[mem_addr] <= mem_wdata;

  always @(negedge clk) begin
    rdy_cnt <= rdy_cnt + 1;
    mem_ready <= stall ? ((rdy_cnt % 3) != 0) : 1'b1;
  end

  // {opcode, hl, de, bc, acc, flags}
  localparam logic [47:0] VEC [NV] = '{
    {8'hA0, 8'h10, 8'h80, 8'h05, 8'h00, 8'hC1},
    {8'hA8, 8'h20, 8'h90, 8'h01, 8'h00, 8'hFF},
    {8'hB0, 8'h30, 8'hA0, 8'h10, 8'h00, 8'h00},
    {8'hB8, 8'h4F, 8'hBF, 8'h10, 8'h00, 8'h28},
    {8'hB0, 8'h50, 8'h52, 8'h08, 8'h00, 8'h00},
    {8'hB8, 8'h67, 8'h6A, 8'h08, 8'h00, 8'h00},
    {8'hA1, 8'h12, 8'h00, 8'h03, 8'h48, 8'h01},
    {8'hA9, 8'h13, 8'h00, 8'h01, 8'h00, 8'h00},
    {8'hB1, 8'hF0, 8'h33, 8'h10, 8'hAF, 8'h01},
    {8'hB9, 8'hFF, 8'h44, 8'h08, 8'h00, 8'h00},
    {8'hB0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
    {8'hB9, 8'hC0, 8'h00, 8'h00, 8'h5A, 8'h80}
  };

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // independent reference of the instruction set
  task automatic model(input logic [7:0] op, inout logic [7:0] h, inout logic [7:0] d,
                       inout logic [7:0] b, input logic [7:0] a, inout logic [7:0] f);
    bit srch, dn, rp, stop;
    logic [7:0] m, r;
    srch = op[0]; dn = op[3]; rp = op[4];
    stop = 1'b0;
    while (!stop) begin
      m = ref_mem[h];
      b = b - 8'd1;
      if (!srch) begin
        ref_mem[d] = m;
        f = (f & 8'hE9) | ((b != 0) ? 8'h04 : 8'h00);
        d = dn ? d - 8'd1 : d + 8'd1;
      end else begin
        r = a - m;
        f = (f & 8'h29) | (r[7] ? 8'h80 : 8'h00) | ((r == 0) ? 8'h40 : 8'h00)
          | (((a & 8'h0F) < (m & 8'h0F)) ? 8'h10 : 8'h00) | 8'h02 | ((b != 0) ? 8'h04 : 8'h00);
      end
      h = dn ? h - 8'd1 : h + 8'd1;
      stop = !rp || (b == 0) || (srch && (a == m));
    end
  endtask

  task automatic load(input logic [7:0] h, input logic [7:0] d, input logic [7:0] b,
                      input logic [7:0] a, input logic [7:0] f);
    @(negedge clk);
    ld_en = 1'b1; ld_hl = h; ld_de = d; ld_bc = b; ld_acc = a; ld_flags = f;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic kick(input logic [7:0] op, output int lat, output bit bsy_seen);
    @(negedge clk);
    start = 1'b1; opcode = op;
    @(negedge clk);
    start = 1'b0;
    bsy_seen = busy;
    lat = 0;
    while (!done && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      ref_mem[i] = 8'(i) ^ 8'h5A;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(hl == 0 && de == 0 && bc == 0, "R1", "pointers in reset", {hl, de, bc}, 0);
    chk(acc == 0 && flags == 0, "R1", "acc/flags in reset", {acc, flags}, 0);
    chk(!busy && !done && !illegal && !mem_valid, "R1", "controls in reset",
        {busy, done, illegal, mem_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_valid, "R1", "idle after reset", {busy, mem_valid}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] op, h, d, b, a, f;
      int lat;
      bit bsy;
      string rq;
      {op, h, d, b, a, f} = VEC[v];
      stall = v[0];
      load(h, d, b, a, f);
      model(op, h, d, b, a, f);
      kick(op, lat, bsy);
      rq = op[0] ? (op[4] ? "R8" : "R7") : (op[4] ? "R6" : "R5");
      chk(done && !illegal, "R2", "legal opcode completes", {done, illegal}, 2);
      chk(bsy, "R13", "busy after start", bsy, 1);
      chk(hl == h, op[0] ? "R7" : "R4", "hl", hl, h);
      chk(de == d, op[0] ? "R7" : "R4", "de", de, d);
      chk(bc == b, (VEC[v][23:16] == 0) ? "R9" : "R4", "bc", bc, b);
      chk(acc == a, "R7", "acc kept", acc, a);
      chk(flags == f, rq, "flags", flags, f);
      begin
        int bad = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) bad++;
        chk(bad == 0, stall ? "R10" : (op[0] ? "R7" : "R3"), "memory mismatches", bad, 0);
      end
      @(negedge clk);
      chk(!done, "R13", "done single cycle", done, 0);
    end

    // R11 illegal opcodes
    stall = 1'b0;
    load(8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
    foreach (VEC[k]) begin end
    begin
      int lat;
      bit bsy;
      kick(8'hA2, lat, bsy);
      chk(done && illegal && lat == 0, "R11", "illegal pulse latency", lat, 0);
      chk(hl == 8'h11 && de == 8'h22 && bc == 8'h33 && acc == 8'h44 && flags == 8'h55,
          "R11", "registers untouched", {hl, de, bc, acc, flags}, 40'h1122334455);
      kick(8'h44, lat, bsy);
      chk(illegal && !bsy, "R11", "second illegal opcode", {illegal, bsy}, 2);
    end

    // R12 load ignored while busy
    begin
      logic [7:0] h, d, b, a, f;
      h = 8'hC0; d = 8'hD0; b = 8'h20; a = 8'h00; f = 8'h00;
      stall = 1'b1;
      load(h, d, b, a, f);
      model(8'hB0, h, d, b, a, f);
      @(negedge clk);
      start = 1'b1; opcode = 8'hB0;
      @(negedge clk);
      start = 1'b0;
      ld_en = 1'b1; ld_hl = 8'h01; ld_de = 8'h02; ld_bc = 8'h03; ld_acc = 8'h77; ld_flags = 8'hFF;
      repeat (10) @(negedge clk);
      ld_en = 1'b0;
      while (!done) @(negedge clk);
      chk(hl == h && de == d && bc == b, "R12", "pointers after busy load", {hl, de, bc}, {h, d, b});
      chk(acc == a && flags == f, "R12", "acc/flags after busy load", {acc, flags}, {a, f});
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule